// File: doc/BRIEF.md
# Configuration-Register Instruction Expander

This block is the issue stage of a DSP core in which a narrow 24-bit instruction selects one of eight wide control words that were loaded earlier. It fetches instructions in order from a local instruction store. For each instruction it reads the selected 128-bit configuration register and merges it with the instruction's own operand field. The result is a registered bundle of per-unit control fields for the multiplier, ALU, shifter, bit unit and vector-register port, plus a mode byte that sets arithmetic width, saturation and a shift amount.

A dedicated load opcode fills one configuration register from four consecutive 32-bit words of data memory. Issue stalls while the load runs. The execution units are outside the block. The only exception is a pair of 40-bit accumulators with selectable width and optional saturation, which make the mode byte observable at the ports.

Top module: `cfg_issue_expander`

## Requirements
- R1: Instructions are fetched in address order from the instruction store starting at address 0 after reset. The layout is opcode [23:18], selector cn [17:15] and operand [14:0]. An issued instruction appears on the issue outputs with its opcode and operand. Instructions without a load between them issue on consecutive cycles.
- R2: An issued instruction drives the control fields from configuration register cn: multiplier = [127:104], ALU = [103:80], shifter = [79:56], bit unit = [55:32], mode = [7:0].
- R3: The vector-register control is configuration bits [31:8] plus the zero-extended 15-bit operand, modulo 2^24.
- R4: Opcode 6'h3F loads configuration register cn from data words at addresses operand, operand+1, operand+2 and operand+3. Word k lands in bits [32k+31:32k]. The load instruction itself is never issued. Data memory answers a read one cycle after the request.
- R5: A load holds issue for four cycles. The instruction after a load issues six cycles after the instruction before it, and each further back-to-back load adds five more cycles.
- R6: The instruction after a load sees the new contents, including when it selects the register just loaded. Other configuration registers are not changed by the load.
- R7: Opcode 6'h01 adds sext(operand[13:0]) shifted left by mode[7:3] to accumulator operand[14]. The other accumulator is unchanged. The accumulator update is visible in the same cycle as the issue.
- R8: mode[1:0] selects the accumulate width: 0 gives 16 bits, 1 gives 32 bits, and 2 or 3 give 40 bits. With mode[2]=1, a result outside the signed range of that width is clamped to its largest or smallest value.
- R9: With mode[2]=0, the result wraps to the selected width and is then sign-extended to 40 bits.
- R10: Opcode 6'h3E stops fetch. Neither it nor any instruction after it issues until reset.
- R11: After reset, the issue valid output, both accumulators and the data-read enable are 0, and every configuration register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Fetch enable |
| imem_we | input | 1 | Instruction store write strobe |
| imem_waddr | input | 9 | Instruction store write address |
| imem_wdata | input | 24 | Instruction store write data |
| dmem_ren | output | 1 | Data memory read request |
| dmem_raddr | output | 15 | Data memory word address |
| dmem_rdata | input | 32 | Data memory read data, one cycle after request |
| issue_valid | output | 1 | Issue bundle valid |
| issue_opc | output | 6 | Issued opcode |
| issue_opnd | output | 15 | Issued operand field |
| ctl_mul | output | 24 | Multiplier control |
| ctl_alu | output | 24 | ALU control |
| ctl_shift | output | 24 | Shifter control |
| ctl_bitu | output | 24 | Bit-unit control |
| ctl_vreg | output | 24 | Vector-register control with operand offset |
| ctl_mode | output | 8 | Width, saturation and shift mode |
| acc0 | output | 40 | Accumulator 0 |
| acc1 | output | 40 | Accumulator 1 |

## Verification
Two functions can fall in the same cycle. The first case is the final configuration write of a load and the release of the held instruction that selects the same register. The bench provokes it by placing an accumulate on cn right after a load of cn. The scoreboard then requires the new mode and fields on that issue, together with a spacing of exactly six cycles. The second case is two loads back to back, where the second is accepted in the cycle the first releases issue. This is judged by an eleven-cycle spacing and by the later issues reading both newly loaded registers.

// File: rtl/cfx_pkg.sv
package cfx_pkg;
  localparam int INSN_W = 24;
  localparam int OPC_W  = 6;
  localparam int CN_W   = 3;
  localparam int OPND_W = 15;
  localparam int CFG_W  = 128;
  localparam int FLD_W  = 24;
  localparam int MODE_W = 8;
  localparam int WORD_W = 32;
  localparam int ACC_W  = 40;
  localparam int EXT_W  = ACC_W + 16;

  localparam logic [OPC_W-1:0] OPC_ACC   = 6'h01;
  localparam logic [OPC_W-1:0] OPC_HALT  = 6'h3E;
  localparam logic [OPC_W-1:0] OPC_CFGLD = 6'h3F;

  typedef struct packed {
    logic [FLD_W-1:0]  mul;
    logic [FLD_W-1:0]  alu;
    logic [FLD_W-1:0]  shf;
    logic [FLD_W-1:0]  bitu;
    logic [FLD_W-1:0]  vreg;
    logic [MODE_W-1:0] mode;
  } cfg_word_t;

  function automatic int width_of(input logic [1:0] wsel);
    case (wsel)
      2'd0:    return 16;
      2'd1:    return 32;
      default: return ACC_W;
    endcase
  endfunction

  function automatic logic signed [EXT_W-1:0] lim_hi(input logic [1:0] wsel);
    logic [EXT_W-1:0] one;
    one = EXT_W'(1);
    return $signed((one << (width_of(wsel) - 1)) - one);
  endfunction

  function automatic logic [ACC_W-1:0] sat_fit(input logic signed [EXT_W-1:0] s,
                                               input logic [1:0] wsel,
                                               input logic sat);
    logic signed [EXT_W-1:0] hi;
    logic signed [EXT_W-1:0] lo;
    logic signed [EXT_W-1:0] r;
    int n;
    n  = width_of(wsel);
    hi = lim_hi(wsel);
    lo = -hi - 1;
    if (sat) begin
      if (s > hi)      r = hi;
      else if (s < lo) r = lo;
      else             r = s;
    end else begin
      r = (s <<< (EXT_W - n)) >>> (EXT_W - n);
    end
    return r[ACC_W-1:0];
  endfunction
endpackage

// File: rtl/cfx_fetch.sv
module cfx_fetch
  import cfx_pkg::*;
#(
  parameter int DEPTH = 384
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run,
  input  logic                     stall,
  input  logic                     halt_now,
  input  logic                     imem_we,
  input  logic [$clog2(DEPTH)-1:0] imem_waddr,
  input  logic [INSN_W-1:0]        imem_wdata,
  output logic [INSN_W-1:0]        ir_o,
  output logic                     ir_valid_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] PC_LAST = AW'(DEPTH - 1);

  logic [INSN_W-1:0] mem [DEPTH];
  logic [INSN_W-1:0] ir_q;
  logic [AW-1:0]     pc_q;
  logic              ir_valid_q;
  logic              halted_q;
  logic              fetch_en;

  assign fetch_en = run && !halted_q && !stall && !halt_now;

  // block-RAM style store: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (imem_we) mem[imem_waddr] <= imem_wdata;
    if (fetch_en) ir_q <= mem[pc_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= '0;
      ir_valid_q <= 1'b0;
      halted_q   <= 1'b0;
    end else if (!stall) begin
      if (halt_now) begin
        halted_q   <= 1'b1;
        ir_valid_q <= 1'b0;
      end else if (fetch_en) begin
        pc_q       <= (pc_q == PC_LAST) ? '0 : pc_q + AW'(1);
        ir_valid_q <= 1'b1;
      end else begin
        ir_valid_q <= 1'b0;
      end
    end
  end

  assign ir_o       = ir_q;
  assign ir_valid_o = ir_valid_q;

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> (!ir_valid_q && $stable(pc_q)));

  // R5
  hold_ir_chk: assert property (@(posedge clk) disable iff (rst)
    (stall && ir_valid_q) |=> (ir_valid_q && $stable(ir_q)));
endmodule

// File: rtl/cfx_cfg_bank.sv
module cfx_cfg_bank
  import cfx_pkg::*;
#(
  parameter int NUM_CFG = 8,
  parameter int ADDR_W  = 15
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ld_req,
  input  logic [$clog2(NUM_CFG)-1:0] ld_sel,
  input  logic [ADDR_W-1:0]          ld_base,
  input  logic [$clog2(NUM_CFG)-1:0] rd_sel,
  output logic [CFG_W-1:0]           rd_word,
  output logic                       busy,
  output logic                       mem_ren,
  output logic [ADDR_W-1:0]          mem_raddr,
  input  logic [WORD_W-1:0]          mem_rdata
);
  localparam int SEL_W    = $clog2(NUM_CFG);
  localparam int LD_WORDS = CFG_W / WORD_W;
  localparam int CNT_W    = $clog2(LD_WORDS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LD_WORDS - 1);

  logic [CFG_W-1:0]  cfg_q [NUM_CFG];
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic [SEL_W-1:0]  sel_q;
  logic              wr_pend_q;
  logic [CNT_W-1:0]  wr_idx_q;
  logic [SEL_W-1:0]  wr_sel_q;
  logic              accept;

  assign accept    = ld_req && !busy_q;
  // word 0 is requested in the decode cycle, words 1..N-1 during busy
  assign mem_ren   = accept || (busy_q && (cnt_q != CNT_LAST));
  assign mem_raddr = busy_q ? (base_q + ADDR_W'(cnt_q) + ADDR_W'(1)) : ld_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
      sel_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      base_q <= ld_base;
      sel_q  <= ld_sel;
    end else if (busy_q) begin
      if (cnt_q == CNT_LAST) busy_q <= 1'b0;
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // tag each outstanding read with its destination slice
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_pend_q <= 1'b0;
      wr_idx_q  <= '0;
      wr_sel_q  <= '0;
    end else begin
      wr_pend_q <= mem_ren;
      wr_idx_q  <= accept ? '0 : cnt_q + CNT_W'(1);
      wr_sel_q  <= accept ? ld_sel : sel_q;
    end
  end

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[g] <= '0;
      end else if (wr_pend_q && (wr_sel_q == SEL_W'(g))) begin
        cfg_q[g][wr_idx_q*WORD_W +: WORD_W] <= mem_rdata;
      end
    end
  end

  assign rd_word = cfg_q[rd_sel];
  assign busy    = busy_q;

  // R5
  no_reload_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !ld_req);
endmodule

// File: rtl/cfx_sat_acc.sv
module cfx_sat_acc
  import cfx_pkg::*;
#(
  parameter int NUM_ACC = 2,
  parameter int VAL_W   = 14
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   en,
  input  logic [(NUM_ACC > 1 ? $clog2(NUM_ACC) : 1)-1:0] sel,
  input  logic [VAL_W-1:0]                       val,
  input  logic [MODE_W-1:0]                      mode,
  output logic [NUM_ACC-1:0][ACC_W-1:0]          acc_o
);
  localparam int SEL_W = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1;

  logic signed [EXT_W-1:0] addend;
  logic [ACC_W-1:0]        acc_q [NUM_ACC];

  assign addend = $signed({{(EXT_W-VAL_W){val[VAL_W-1]}}, val}) <<< mode[7:3];

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    logic signed [EXT_W-1:0] cur;
    logic signed [EXT_W-1:0] sum;
    assign cur = $signed({{(EXT_W-ACC_W){acc_q[g][ACC_W-1]}}, acc_q[g]});
    assign sum = cur + addend;

    always_ff @(posedge clk) begin
      if (rst) begin
        acc_q[g] <= '0;
      end else if (en && (sel == SEL_W'(g))) begin
        acc_q[g] <= sat_fit(sum, mode[1:0], mode[2]);
      end
    end

    assign acc_o[g] = acc_q[g];

    // R8
    acc_range_chk: assert property (@(posedge clk) disable iff (rst)
      (en && (sel == SEL_W'(g)) && mode[2]) |=>
        ((cur <= lim_hi($past(mode[1:0]))) && (cur >= -lim_hi($past(mode[1:0])) - 1)));

    // R7
    acc_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (!en || (sel != SEL_W'(g))) |=> $stable(acc_q[g]));
  end
endmodule

// File: rtl/cfg_issue_expander.sv
module cfg_issue_expander
  import cfx_pkg::*;
#(
  parameter int IMEM_DEPTH = 384
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          run,
  input  logic                          imem_we,
  input  logic [$clog2(IMEM_DEPTH)-1:0] imem_waddr,
  input  logic [23:0]                   imem_wdata,
  output logic                          dmem_ren,
  output logic [14:0]                   dmem_raddr,
  input  logic [31:0]                   dmem_rdata,
  output logic                          issue_valid,
  output logic [5:0]                    issue_opc,
  output logic [14:0]                   issue_opnd,
  output logic [23:0]                   ctl_mul,
  output logic [23:0]                   ctl_alu,
  output logic [23:0]                   ctl_shift,
  output logic [23:0]                   ctl_bitu,
  output logic [23:0]                   ctl_vreg,
  output logic [7:0]                    ctl_mode,
  output logic [39:0]                   acc0,
  output logic [39:0]                   acc1
);
  localparam int NUM_CFG = 1 << CN_W;
  localparam int NUM_ACC = 2;

  logic [INSN_W-1:0]  ir;
  logic               ir_valid;
  logic [OPC_W-1:0]   opc;
  logic [CN_W-1:0]    cn;
  logic [OPND_W-1:0]  opnd;
  logic               busy;
  logic               dec_ok;
  logic               ld_req;
  logic               halt_now;
  logic               fire;
  logic               acc_en;
  logic [CFG_W-1:0]   rd_word;
  cfg_word_t          cw;
  logic [NUM_ACC-1:0][ACC_W-1:0] acc_w;

  assign opc  = ir[23:18];
  assign cn   = ir[17:15];
  assign opnd = ir[14:0];

  assign dec_ok   = ir_valid && !busy;
  assign ld_req   = dec_ok && (opc == OPC_CFGLD);
  assign halt_now = dec_ok && (opc == OPC_HALT);
  assign fire     = dec_ok && (opc != OPC_CFGLD) && (opc != OPC_HALT);
  assign acc_en   = fire && (opc == OPC_ACC);

  cfx_fetch #(.DEPTH(IMEM_DEPTH)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .stall      (busy),
    .halt_now   (halt_now),
    .imem_we    (imem_we),
    .imem_waddr (imem_waddr),
    .imem_wdata (imem_wdata),
    .ir_o       (ir),
    .ir_valid_o (ir_valid)
  );

  cfx_cfg_bank #(.NUM_CFG(NUM_CFG), .ADDR_W(OPND_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .ld_req    (ld_req),
    .ld_sel    (cn),
    .ld_base   (opnd),
    .rd_sel    (cn),
    .rd_word   (rd_word),
    .busy      (busy),
    .mem_ren   (dmem_ren),
    .mem_raddr (dmem_raddr),
    .mem_rdata (dmem_rdata)
  );

  assign cw = cfg_word_t'(rd_word);

  cfx_sat_acc #(.NUM_ACC(NUM_ACC), .VAL_W(OPND_W-1)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .en    (acc_en),
    .sel   (opnd[OPND_W-1]),
    .val   (opnd[OPND_W-2:0]),
    .mode  (cw.mode),
    .acc_o (acc_w)
  );

  assign acc0 = acc_w[0];
  assign acc1 = acc_w[1];

  // registered issue bundle: configuration word merged with the instruction
  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      issue_opc   <= '0;
      issue_opnd  <= '0;
      ctl_mul     <= '0;
      ctl_alu     <= '0;
      ctl_shift   <= '0;
      ctl_bitu    <= '0;
      ctl_vreg    <= '0;
      ctl_mode    <= '0;
    end else begin
      issue_valid <= fire;
      if (fire) begin
        issue_opc  <= opc;
        issue_opnd <= opnd;
        ctl_mul    <= cw.mul;
        ctl_alu    <= cw.alu;
        ctl_shift  <= cw.shf;
        ctl_bitu   <= cw.bitu;
        ctl_vreg   <= cw.vreg + FLD_W'(opnd);
        ctl_mode   <= cw.mode;
      end
    end
  end

  // R5
  stall_issue_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !issue_valid);

  // R4 R10
  no_ctl_issue_chk: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> ((issue_opc != OPC_CFGLD) && (issue_opc != OPC_HALT)));
endmodule

// File: tb/cfg_issue_expander_tb.sv
module cfg_issue_expander_tb;
  import cfx_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, run, imem_we;
  logic [8:0]  imem_waddr;
  logic [23:0] imem_wdata;
  logic        dmem_ren;
  logic [14:0] dmem_raddr;
  logic [31:0] dmem_rdata;
  logic        issue_valid;
  logic [5:0]  issue_opc;
  logic [14:0] issue_opnd;
  logic [23:0] ctl_mul, ctl_alu, ctl_shift, ctl_bitu, ctl_vreg;
  logic [7:0]  ctl_mode;
  logic [39:0] acc0, acc1;

  cfg_issue_expander u_dut (
    .clk(clk), .rst(rst), .run(run),
    .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
    .dmem_ren(dmem_ren), .dmem_raddr(dmem_raddr), .dmem_rdata(dmem_rdata),
    .issue_valid(issue_valid), .issue_opc(issue_opc), .issue_opnd(issue_opnd),
    .ctl_mul(ctl_mul), .ctl_alu(ctl_alu), .ctl_shift(ctl_shift),
    .ctl_bitu(ctl_bitu), .ctl_vreg(ctl_vreg), .ctl_mode(ctl_mode),
    .acc0(acc0), .acc1(acc1)
  );

  // data memory model, one-cycle read latency
  logic [31:0] dmem [64];
  always @(posedge clk) if (dmem_ren) dmem_rdata <= dmem[dmem_raddr[5:0]];

  typedef struct {
    logic [5:0]   opc;
    logic [14:0]  opnd;
    logic [127:0] cw;
    logic [23:0]  vreg;
    logic [39:0]  a0;
    logic [39:0]  a1;
    int           gap;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  logic [127:0] mcfg [8];
  longint       macc [2];
  int           pend_ld;
  bit           first_issue;
  bit           mhalt;
  int           wptr;
  int           checks = 0;
  int           fails  = 0;
  longint       cyc = 0;
  longint       last_cyc = 0;
  bit           mon_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint mfit(longint s, logic [1:0] w, bit sat);
    int n;
    longint hi, lo;
    n  = (w == 2'd0) ? 16 : (w == 2'd1) ? 32 : 40;
    hi = (longint'(1) <<< (n - 1)) - 1;
    lo = -hi - 1;
    if (sat) return (s > hi) ? hi : ((s < lo) ? lo : s);
    return (s <<< (64 - n)) >>> (64 - n);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: writes one instruction and pushes its expected issue
  task automatic put(logic [5:0] opc, logic [2:0] cn, logic [14:0] opnd, string tag);
    exp_t e;
    longint add;
    int k;
    imem_we    = 1'b1;
    imem_waddr = 9'(wptr);
    imem_wdata = {opc, cn, opnd};
    @(negedge clk);
    imem_we = 1'b0;
    wptr++;
    if (mhalt) return;
    if (opc == OPC_CFGLD) begin
      for (int j = 0; j < 4; j++) begin
        k = (int'(opnd) + j) % 64;
        mcfg[cn][32*j +: 32] = dmem[k];
      end
      pend_ld++;
    end else if (opc == OPC_HALT) begin
      mhalt = 1'b1;
    end else begin
      e.opc  = opc;
      e.opnd = opnd;
      e.cw   = mcfg[cn];
      e.vreg = mcfg[cn][31:8] + 24'(opnd);
      if (opc == OPC_ACC) begin
        add = longint'($signed(opnd[13:0])) <<< mcfg[cn][7:3];
        macc[int'(opnd[14])] = mfit(macc[int'(opnd[14])] + add, mcfg[cn][1:0], mcfg[cn][2]);
      end
      e.a0  = 40'(macc[0]);
      e.a1  = 40'(macc[1]);
      e.gap = first_issue ? 0 : 1 + 5 * pend_ld;
      e.tag = tag;
      first_issue = 1'b0;
      pend_ld = 0;
      sb.push_back(e);
    end
  endtask

  // monitor: pops one expected item per issue
  always @(negedge clk) begin
    if (mon_on && issue_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R10 unexpected issue", longint'(issue_opc), 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(issue_opc == e.opc, {"R1 opcode ", e.tag}, issue_opc, e.opc);
        chk(issue_opnd == e.opnd, {"R1 operand ", e.tag}, issue_opnd, e.opnd);
        chk(ctl_mul == e.cw[127:104], {"R2 mul ", e.tag}, ctl_mul, e.cw[127:104]);
        chk(ctl_alu == e.cw[103:80], {"R2 alu ", e.tag}, ctl_alu, e.cw[103:80]);
        chk(ctl_shift == e.cw[79:56], {"R2 shift ", e.tag}, ctl_shift, e.cw[79:56]);
        chk(ctl_bitu == e.cw[55:32], {"R2 bitu ", e.tag}, ctl_bitu, e.cw[55:32]);
        chk(ctl_mode == e.cw[7:0], {"R2 mode ", e.tag}, ctl_mode, e.cw[7:0]);
        chk(ctl_vreg == e.vreg, {"R3 vreg ", e.tag}, ctl_vreg, e.vreg);
        chk(acc0 == e.a0, {"R7 acc0 ", e.tag}, acc0, e.a0);
        chk(acc1 == e.a1, {"R7 acc1 ", e.tag}, acc1, e.a1);
        if (e.gap != 0)
          chk(cyc - last_cyc == longint'(e.gap), {"R5 spacing ", e.tag}, cyc - last_cyc, e.gap);
      end
      last_cyc = cyc;
    end
  end

  task automatic do_reset();
    rst = 1'b1; run = 1'b0; imem_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 8; i++) mcfg[i] = '0;
    macc[0] = 0; macc[1] = 0;
    pend_ld = 0; first_issue = 1'b1; mhalt = 1'b0; wptr = 0;
    sb.delete();
    chk(issue_valid == 1'b0, "R11 issue_valid after reset", issue_valid, 0);
    chk(acc0 == 40'd0, "R11 acc0 after reset", acc0, 0);
    chk(acc1 == 40'd0, "R11 acc1 after reset", acc1, 0);
    chk(dmem_ren == 1'b0, "R11 dmem_ren after reset", dmem_ren, 0);
  endtask

  task automatic execute();
    mon_on = 1'b1;
    run = 1'b1;
    for (int i = 0; i < 2000 && sb.size() != 0; i++) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(sb.size() == 0, "R1 all expected issues seen", sb.size(), 0);
    run = 1'b0;
    mon_on = 1'b0;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] modes [6];
    modes[0] = 8'h24;  // 16-bit, saturate, shift 4
    modes[1] = 8'h20;  // 16-bit, wrap, shift 4
    modes[2] = 8'hA5;  // 32-bit, saturate, shift 20
    modes[3] = 8'hFE;  // 40-bit, saturate, shift 31
    modes[4] = 8'hFB;  // 40-bit (code 3), wrap, shift 31
    modes[5] = 8'h91;  // 32-bit, wrap, shift 18
    for (int i = 0; i < 64; i++) dmem[i] = (32'(i + 1) * 32'h9E3779B1) ^ 32'h0F1E2D3C;
    for (int s = 0; s < 6; s++) dmem[4*s][7:0] = modes[s];
    imem_waddr = '0; imem_wdata = '0;

    // program 1
    do_reset();
    put(6'h01, 3'd0, 15'd5,                 "R11 zero config, R9 wrap16");
    put(6'h3F, 3'd2, 15'd0,                 "R4 load c2");
    put(6'h01, 3'd2, 15'd2000,              "R6 same-cn after load, R8");
    put(6'h01, 3'd2, 15'd2000,              "R8 clamp high 16");
    put(6'h05, 3'd2, 15'h1234,              "R3 vreg offset");
    put(6'h01, 3'd2, {1'b1, 14'(-3000)},    "R8 clamp low 16 acc1");
    put(6'h3F, 3'd2, 15'd4,                 "R6 reload c2");
    put(6'h01, 3'd2, 15'd100,               "R9 wrap16 after reload");
    put(6'h3F, 3'd3, 15'd8,                 "R4 load c3");
    put(6'h3F, 3'd4, 15'd12,                "R5 back-to-back load c4");
    put(6'h01, 3'd3, 15'd8191,              "R8 clamp high 32");
    put(6'h01, 3'd4, {1'b1, 14'd8191},      "R8 clamp high 40");
    put(6'h3F, 3'd5, 15'd16,                "R4 load c5");
    put(6'h01, 3'd5, {1'b1, 14'd1},         "R9 wrap40 code3");
    put(6'h07, 3'd3, 15'h7FFF,              "R3 vreg wrap");
    put(6'h3E, 3'd0, 15'd0,                 "R10 halt");
    put(6'h01, 3'd0, 15'd1,                 "R10 after halt");
    put(6'h09, 3'd2, 15'd3,                 "R10 after halt");
    execute();

    // program 2
    do_reset();
    put(6'h0A, 3'd2, 15'd0,                 "R11 c2 cleared by reset");
    put(6'h01, 3'd0, 15'h3FFF,              "R9 wrap16 negative");
    put(6'h3F, 3'd6, 15'd20,                "R4 load c6");
    put(6'h01, 3'd6, {1'b1, 14'd8191},      "R7 acc1 32-bit");
    put(6'h01, 3'd6, {1'b1, 14'd8191},      "R9 wrap32");
    put(6'h0B, 3'd1, 15'd9,                 "R6 c1 untouched");
    put(6'h3E, 3'd0, 15'd0,                 "R10 halt");
    put(6'h02, 3'd6, 15'd1,                 "R10 after halt");
    execute();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule